// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state update that a 32-bit processor core makes when it takes an exception or a debug trap. Each cycle it can receive one normal exception, with a faulting PC, a cause code and an optional faulting virtual address. It can also receive a debug request with its own cause code. The core supplies its current status word. In the next cycle the block presents the updated architectural registers, the new status word and a one-cycle entry strobe with a 2-bit vector code.

The vector code is kernel `00`, user `01`, double `10` or debug `11`. The status word is 6 bits wide. Bits [3:0] hold the interrupt level, bit 4 is user mode and bit 5 is exception mode.

Saved PCs and saved status words live in a bank indexed by level 1 to 7. The bank is read through a level-select port, and level 0 always reads zero. The parameter `DBG_LEVEL` (2 to 7, default 6) picks the debug level. The parameter `HAS_DEPC` (default 1) adds a dedicated double-exception PC register.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, every output is zero: the strobe, the vector, the cause, the virtual address, the debug cause, the status, the double-exception PC and both bank read ports.
- R2: A normal exception with status bit 5 and bit 4 clear gives vector `00` and stores the PC in the level-1 saved-PC entry.
- R3: A normal exception with bit 5 clear and bit 4 set gives vector `01` and stores the PC in the level-1 saved-PC entry.
- R4: A normal exception with bit 5 already set gives vector `10`. With `HAS_DEPC`=1 the PC goes to the double-exception PC register and the level-1 entry is left unchanged.
- R5: Every accepted normal exception writes the cause register. The new status equals the incoming status with bit 5 set.
- R6: The virtual-address register is written only by a normal exception whose address-valid input is high. Otherwise it holds its value.
- R7: A debug request is accepted only when status bits [3:0] are strictly below `DBG_LEVEL`. A rejected request changes nothing. A normal exception arriving with a rejected request is taken as usual.
- R8: A debug entry gives vector `11`. It writes the debug cause and stores the PC and the old status in bank entry `DBG_LEVEL`. The new status keeps bit 4, sets bit 5 and sets bits [3:0] to `DBG_LEVEL`. The cause and virtual-address registers are untouched.
- R9: When a debug request is accepted in the same cycle as a normal exception, only the debug entry takes place and the normal exception is dropped.
- R10: The entry strobe is high in the cycle after each accepted event, for exactly that cycle, and low after any cycle with no accepted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| exc_valid_i | input | 1 | Normal exception request |
| exc_pc_i | input | 32 | PC of the faulting instruction, also used for debug entry |
| exc_cause_i | input | 6 | Exception cause code |
| exc_va_valid_i | input | 1 | Exception carries a faulting virtual address |
| exc_va_i | input | 32 | Faulting virtual address |
| dbg_req_i | input | 1 | Debug trap request |
| dbg_cause_i | input | 6 | Debug cause code |
| stat_i | input | 6 | Current status: [3:0] level, [4] user, [5] exception mode |
| lvl_sel_i | input | 3 | Bank level to read (0 reads zero) |
| enter_o | output | 1 | One-cycle entry strobe |
| vec_o | output | 2 | Vector code of the last entry |
| cause_o | output | 6 | Exception cause register |
| va_o | output | 32 | Faulting virtual-address register |
| dbg_cause_o | output | 6 | Debug cause register |
| stat_o | output | 6 | Status produced by the last entry |
| depc_o | output | 32 | Double-exception PC register |
| lvl_epc_o | output | 32 | Saved PC of the selected level |
| lvl_eps_o | output | 6 | Saved status of the selected level |

## Verification
The bound checker watches, on every cycle, the relations between the request inputs and the registered outputs. These are vector selection for debug and double entries, the level gate on debug requests, cause capture, holding the virtual address, the exception-mode bit after entry, and debug priority over a simultaneous exception. The contents of the level bank, the choice between the level-1 entry and the double-exception register, and the exact new status after a debug entry are shown only by the bench scenarios. Those scenarios read each bank level back and compare it with a reference model.

// File: rtl/exc_entry_pkg.sv
`timescale 1ns/1ps
package exc_entry_pkg;
    localparam int STAT_W   = 6;
    localparam int ILVL_W   = 4;
    localparam int UM_BIT   = 4;
    localparam int EXCM_BIT = 5;

    typedef enum logic [1:0] {
        VEC_KERNEL = 2'b00,
        VEC_USER   = 2'b01,
        VEC_DOUBLE = 2'b10,
        VEC_DEBUG  = 2'b11
    } vec_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'b00,
        EV_NORMAL = 2'b01,
        EV_DEBUG  = 2'b10
    } ev_e;
endpackage

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter int DBG_LEVEL = 6
) (
    input  logic              exc_valid_i,
    input  logic              dbg_req_i,
    input  logic [STAT_W-1:0] stat_i,
    output ev_e               ev_o,
    output vec_e              vec_o
);
    logic dbg_ok;

    always_comb begin
        dbg_ok = dbg_req_i && (stat_i[ILVL_W-1:0] < ILVL_W'(DBG_LEVEL));
        ev_o   = EV_NONE;
        vec_o  = VEC_KERNEL;
        if (dbg_ok) begin
            ev_o  = EV_DEBUG;
            vec_o = VEC_DEBUG;
        end else if (exc_valid_i) begin
            ev_o = EV_NORMAL;
            if (stat_i[EXCM_BIT]) begin
                vec_o = VEC_DOUBLE;
            end else if (stat_i[UM_BIT]) begin
                vec_o = VEC_USER;
            end else begin
                vec_o = VEC_KERNEL;
            end
        end
    end
endmodule

// File: rtl/exc_level_bank.sv
`timescale 1ns/1ps
module exc_level_bank
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int LVL_W     = 3,
    parameter int DBG_LEVEL = 6,
    parameter int HAS_DEPC  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  ev_e               ev_i,
    input  logic [XLEN-1:0]   pc_i,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [LVL_W-1:0]  rd_sel_i,
    output logic [XLEN-1:0]   rd_epc_o,
    output logic [STAT_W-1:0] rd_eps_o
);
    localparam int NENT = 1 << LVL_W;
    localparam bit DOUBLE_TO_L1 = (HAS_DEPC == 0);

    logic [XLEN-1:0]   epc_d [NENT];
    logic [XLEN-1:0]   epc_q [NENT];
    logic [STAT_W-1:0] eps_d [NENT];
    logic [STAT_W-1:0] eps_q [NENT];

    always_comb begin
        for (int i = 0; i < NENT; i++) begin
            epc_d[i] = epc_q[i];
            eps_d[i] = eps_q[i];
        end
        if (ev_i == EV_DEBUG) begin
            epc_d[DBG_LEVEL] = pc_i;
            eps_d[DBG_LEVEL] = stat_i;
        end else if (ev_i == EV_NORMAL) begin
            if (!stat_i[EXCM_BIT] || DOUBLE_TO_L1) begin
                epc_d[1] = pc_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < NENT; i++) begin
            if (!rst_ni) begin
                epc_q[i] <= '0;
                eps_q[i] <= '0;
            end else begin
                epc_q[i] <= epc_d[i];
                eps_q[i] <= eps_d[i];
            end
        end
    end

    assign rd_epc_o = epc_q[rd_sel_i];
    assign rd_eps_o = eps_q[rd_sel_i];
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int LVL_W     = 3,
    parameter int DBG_LEVEL = 6,
    parameter int HAS_DEPC  = 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               exc_valid_i,
    input  logic [XLEN-1:0]    exc_pc_i,
    input  logic [CAUSE_W-1:0] exc_cause_i,
    input  logic               exc_va_valid_i,
    input  logic [XLEN-1:0]    exc_va_i,
    input  logic               dbg_req_i,
    input  logic [CAUSE_W-1:0] dbg_cause_i,
    input  logic [STAT_W-1:0]  stat_i,
    input  logic [LVL_W-1:0]   lvl_sel_i,
    output logic               enter_o,
    output logic [1:0]         vec_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [XLEN-1:0]    va_o,
    output logic [CAUSE_W-1:0] dbg_cause_o,
    output logic [STAT_W-1:0]  stat_o,
    output logic [XLEN-1:0]    depc_o,
    output logic [XLEN-1:0]    lvl_epc_o,
    output logic [STAT_W-1:0]  lvl_eps_o
);
    typedef struct packed {
        logic               enter;
        vec_e               vec;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    va;
        logic [CAUSE_W-1:0] dbgc;
        logic [STAT_W-1:0]  stat;
    } core_t;

    ev_e   ev;
    vec_e  vec_sel;
    core_t core_d, core_q;

    exc_arbiter #(.DBG_LEVEL(DBG_LEVEL)) i_arb (
        .exc_valid_i (exc_valid_i),
        .dbg_req_i   (dbg_req_i),
        .stat_i      (stat_i),
        .ev_o        (ev),
        .vec_o       (vec_sel)
    );

    exc_level_bank #(
        .XLEN      (XLEN),
        .LVL_W     (LVL_W),
        .DBG_LEVEL (DBG_LEVEL),
        .HAS_DEPC  (HAS_DEPC)
    ) i_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ev_i     (ev),
        .pc_i     (exc_pc_i),
        .stat_i   (stat_i),
        .rd_sel_i (lvl_sel_i),
        .rd_epc_o (lvl_epc_o),
        .rd_eps_o (lvl_eps_o)
    );

    always_comb begin
        core_d       = core_q;
        core_d.enter = 1'b0;
        unique case (ev)
            EV_DEBUG: begin
                core_d.enter = 1'b1;
                core_d.vec   = vec_sel;
                core_d.dbgc  = dbg_cause_i;
                core_d.stat  = stat_i;
                core_d.stat[EXCM_BIT]     = 1'b1;
                core_d.stat[ILVL_W-1:0]   = ILVL_W'(DBG_LEVEL);
            end
            EV_NORMAL: begin
                core_d.enter = 1'b1;
                core_d.vec   = vec_sel;
                core_d.cause = exc_cause_i;
                if (exc_va_valid_i) begin
                    core_d.va = exc_va_i;
                end
                core_d.stat = stat_i;
                core_d.stat[EXCM_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    generate
        if (HAS_DEPC != 0) begin : g_depc
            logic [XLEN-1:0] depc_d, depc_q;
            always_comb begin
                depc_d = depc_q;
                if (ev == EV_NORMAL && stat_i[EXCM_BIT]) begin
                    depc_d = exc_pc_i;
                end
            end
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    depc_q <= '0;
                end else begin
                    depc_q <= depc_d;
                end
            end
            assign depc_o = depc_q;
        end else begin : g_no_depc
            assign depc_o = '0;
        end
    endgenerate

    assign enter_o     = core_q.enter;
    assign vec_o       = core_q.vec;
    assign cause_o     = core_q.cause;
    assign va_o        = core_q.va;
    assign dbg_cause_o = core_q.dbgc;
    assign stat_o      = core_q.stat;
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns/1ps
module exc_entry_chk #(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int LVL_W     = 3,
    parameter int DBG_LEVEL = 6,
    parameter int HAS_DEPC  = 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               exc_valid_i,
    input logic [XLEN-1:0]    exc_pc_i,
    input logic [CAUSE_W-1:0] exc_cause_i,
    input logic               exc_va_valid_i,
    input logic [XLEN-1:0]    exc_va_i,
    input logic               dbg_req_i,
    input logic [CAUSE_W-1:0] dbg_cause_i,
    input logic [5:0]         stat_i,
    input logic [LVL_W-1:0]   lvl_sel_i,
    input logic               enter_o,
    input logic [1:0]         vec_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic [XLEN-1:0]    va_o,
    input logic [CAUSE_W-1:0] dbg_cause_o,
    input logic [5:0]         stat_o,
    input logic [XLEN-1:0]    depc_o,
    input logic [XLEN-1:0]    lvl_epc_o,
    input logic [5:0]         lvl_eps_o
);
    logic dbg_ok;
    assign dbg_ok = dbg_req_i && (stat_i[3:0] < 4'(DBG_LEVEL));

    // R10
    enter_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_o |-> $past(exc_valid_i || dbg_req_i));

    // R7
    dbg_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_ok |=> (enter_o && vec_o == 2'b11));

    // R7
    dbg_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_req_i && !dbg_ok && !exc_valid_i) |=> !enter_o);

    // R4
    double_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i && !dbg_ok && stat_i[5]) |=> (enter_o && vec_o == 2'b10));

    // R5
    excm_after_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_o |-> stat_o[5]);

    // R5
    cause_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i && !dbg_ok) |=> cause_o == $past(exc_cause_i));

    // R9
    dbg_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dbg_ok && exc_valid_i) |=> ($stable(cause_o) && $stable(va_o)));

    // R6
    va_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(exc_valid_i && exc_va_valid_i && !dbg_ok) |=> $stable(va_o));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .LVL_W(LVL_W),
    .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)
) i_exc_entry_chk (.*);

// File: tb/test_exc_entry_ctrl.sv
`timescale 1ns/1ps
module test_exc_entry_ctrl;
    localparam int DBG = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [31:0] exc_pc = '0;
    logic [5:0]  exc_cause = '0;
    logic        va_valid = 1'b0;
    logic [31:0] va = '0;
    logic        dbg_req = 1'b0;
    logic [5:0]  dbg_cause = '0;
    logic [5:0]  stat = '0;
    logic [2:0]  sel = '0;

    logic        enter_o;
    logic [1:0]  vec_o;
    logic [5:0]  cause_o;
    logic [31:0] va_o;
    logic [5:0]  dbg_cause_o;
    logic [5:0]  stat_o;
    logic [31:0] depc_o;
    logic [31:0] lvl_epc_o;
    logic [5:0]  lvl_eps_o;

    always #2.5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .exc_valid_i(exc_valid), .exc_pc_i(exc_pc), .exc_cause_i(exc_cause),
        .exc_va_valid_i(va_valid), .exc_va_i(va),
        .dbg_req_i(dbg_req), .dbg_cause_i(dbg_cause),
        .stat_i(stat), .lvl_sel_i(sel),
        .enter_o(enter_o), .vec_o(vec_o), .cause_o(cause_o), .va_o(va_o),
        .dbg_cause_o(dbg_cause_o), .stat_o(stat_o), .depc_o(depc_o),
        .lvl_epc_o(lvl_epc_o), .lvl_eps_o(lvl_eps_o)
    );

    typedef struct {
        int          due;
        string       tag;
        logic        enter;
        logic [1:0]  vec;
        logic [5:0]  cause;
        logic [31:0] va;
        logic [5:0]  dbgc;
        logic [5:0]  stat;
        logic [31:0] depc;
        logic [31:0] epc;
        logic [5:0]  eps;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic        m_enter = 0;
    logic [1:0]  m_vec = 0;
    logic [5:0]  m_cause = 0, m_dbgc = 0, m_stat = 0;
    logic [31:0] m_va = 0, m_depc = 0;
    logic [31:0] m_epc [8];
    logic [5:0]  m_eps [8];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic cmp(string tag, string fld, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            cmp(it.tag, "enter", 32'(enter_o), 32'(it.enter));
            cmp(it.tag, "vec", 32'(vec_o), 32'(it.vec));
            cmp(it.tag, "cause", 32'(cause_o), 32'(it.cause));
            cmp(it.tag, "va", va_o, it.va);
            cmp(it.tag, "dbgcause", 32'(dbg_cause_o), 32'(it.dbgc));
            cmp(it.tag, "stat", 32'(stat_o), 32'(it.stat));
            cmp(it.tag, "depc", depc_o, it.depc);
            cmp(it.tag, "lvl_epc", lvl_epc_o, it.epc);
            cmp(it.tag, "lvl_eps", 32'(lvl_eps_o), 32'(it.eps));
        end
    end

    // driver: one stimulus cycle, model update, expected item pushed
    task automatic step(input logic ev, input logic [31:0] pc, input logic [5:0] c,
                        input logic vv, input logic [31:0] a,
                        input logic dr, input logic [5:0] dc,
                        input logic [5:0] st, input logic [2:0] s, input string tag);
        item_t it;
        logic take;
        @(negedge clk);
        exc_valid = ev; exc_pc = pc; exc_cause = c; va_valid = vv; va = a;
        dbg_req = dr; dbg_cause = dc; stat = st; sel = s;
        take = dr && (st[3:0] < 4'(DBG));
        m_enter = 1'b0;
        if (take) begin
            m_enter = 1'b1; m_vec = 2'b11; m_dbgc = dc;
            m_epc[DBG] = pc; m_eps[DBG] = st;
            m_stat = {1'b1, st[4], 4'(DBG)};
        end else if (ev) begin
            m_enter = 1'b1; m_cause = c;
            if (vv) m_va = a;
            if (st[5]) begin
                m_vec = 2'b10; m_depc = pc;
            end else begin
                m_epc[1] = pc; m_vec = st[4] ? 2'b01 : 2'b00;
            end
            m_stat = st | 6'h20;
        end
        it.due = cyc + 1; it.tag = tag;
        it.enter = m_enter; it.vec = m_vec; it.cause = m_cause; it.va = m_va;
        it.dbgc = m_dbgc; it.stat = m_stat; it.depc = m_depc;
        it.epc = m_epc[s]; it.eps = m_eps[s];
        q.push_back(it);
    endtask

    task automatic idle(input logic [2:0] s, input string tag);
        step(0, 32'h0, 6'h0, 0, 32'h0, 0, 6'h0, 6'h00, s, tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_epc[i] = '0;
            m_eps[i] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state on every output
        idle(3'd1, "R1 reset l1");
        idle(3'd6, "R1 reset l6");
        // R2: kernel entry
        step(1, 32'h0000_1000, 6'd5, 0, 32'h0, 0, 6'h0, 6'h00, 3'd1, "R2 kernel");
        // R10: strobe drops after an idle cycle; R6 holds va
        idle(3'd1, "R10 strobe low R6 hold");
        // R3: user entry with level 2
        step(1, 32'h0000_2004, 6'd9, 0, 32'h0, 0, 6'h0, 6'h12, 3'd1, "R3 user");
        // R6: address-related exception
        step(1, 32'h0000_3008, 6'd28, 1, 32'hDEAD_BEE0, 0, 6'h0, 6'h00, 3'd1, "R6 vaddr");
        // R4: double exception, level-1 entry kept
        step(1, 32'h0000_400C, 6'd3, 0, 32'h1111_1111, 0, 6'h0, 6'h20, 3'd1, "R4 double");
        // R8: debug entry at level 3 with user mode
        step(0, 32'h0000_5010, 6'd0, 0, 32'h0, 1, 6'h11, 6'h13, 3'd6, "R8 debug");
        idle(3'd0, "R1 level0 reads zero");
        // R7: rejected at level equal to DBG, nothing changes
        step(0, 32'h0000_6014, 6'd0, 0, 32'h0, 1, 6'h22, 6'h06, 3'd6, "R7 reject eq");
        // R7: rejected at level 7 with an exception taken normally
        step(1, 32'h0000_7018, 6'd7, 1, 32'h0000_7777, 1, 6'h33, 6'h07, 3'd1, "R7 reject plus exc");
        // R9: debug wins over simultaneous exception
        step(1, 32'h0000_801C, 6'd12, 1, 32'hBAD0_0000, 1, 6'h2A, 6'h05, 3'd6, "R9 debug wins");
        idle(3'd1, "R9 level1 untouched");
        // R10: back-to-back events, each gets its strobe
        step(1, 32'h0000_9020, 6'd1, 0, 32'h0, 0, 6'h0, 6'h00, 3'd1, "R10 b2b a");
        step(1, 32'h0000_9024, 6'd2, 1, 32'h0000_9999, 0, 6'h0, 6'h10, 3'd1, "R10 b2b b");
        step(0, 32'h0000_9028, 6'd0, 0, 32'h0, 1, 6'h05, 6'h00, 3'd6, "R10 b2b c R8");
        idle(3'd6, "R10 strobe low");
        // R4: second double entry updates depc only
        step(1, 32'h0000_A02C, 6'd4, 0, 32'h0, 0, 6'h0, 6'h31, 3'd1, "R4 double again");
        idle(3'd1, "R4 final");
        repeat (4) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule